// File: doc/BRIEF.md
# Carry-Flag Boolean Bit Processor

This unit does single-bit Boolean work on one byte. Each operation names one bit of an 8-bit operand by a 3-bit index. It then does one of three things with that bit and two flags, a carry flag C and a zero flag Z. It can merge the bit into C. It can copy the bit, or its complement, into a flag. It can rewrite the bit from a flag or from a constant. A pipeline hands it the operand byte that has already been fetched, the opcode and the current flags. One clock later it returns the updated flags, the byte to write back, and a strobe that marks whether a write-back is needed.

The computation is combinational and feeds a single registered output stage. The unit does not read or write memory. The surrounding datapath stores the returned byte when the strobe is high.

Top module: `bitproc`

## Requirements
- R1: `bit_sel` value n selects operand bit n, where 0 is the least significant bit. Every bit other than the selected one appears unchanged in `result`.
- R2: Opcode 0 sets C to the selected bit. Opcode 1 sets C to the complement of the selected bit.
- R3: Opcodes 2, 4 and 6 replace C with C AND bit, C OR bit and C XOR bit. Opcodes 3, 5 and 7 do the same with the complement of the bit.
- R4: Opcode 8 writes C into the selected bit. Opcode 9 writes the complement of C into it.
- R5: Opcode 10 writes Z into the selected bit. Opcode 11 writes the complement of Z into it.
- R6: Opcode 15 sets Z to the complement of the selected bit. C is left as it was.
- R7: Opcodes 12, 13 and 14 set the selected bit to 1, clear it to 0, or invert it.
- R8: Opcode 16 sets the bit only when Z=1, and opcode 17 sets it only when Z=0. Opcode 18 clears the bit only when Z=1, and opcode 19 clears it only when Z=0. When the condition fails, the byte is returned unchanged.
- R9: A flag that an operation does not name passes through unchanged. Operations 0–7 and 15 return the operand byte unchanged. Opcodes 20–31 change neither the flags nor the byte.
- R10: `wr_en` is 1 for opcodes 8–14, and for opcodes 16–19 when their condition holds. It is 0 in every other case.
- R11: The outputs register the operation presented with `in_valid` at the next rising edge, and `out_valid` then reads 1. A cycle with `in_valid` low gives `out_valid`=0 and `wr_en`=0, and the flags and `result` hold their previous values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Opcode |
| bit_sel | input | 3 | Index of the bit to work on |
| operand | input | 8 | Operand byte |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Registered result is valid |
| wr_en | output | 1 | Byte must be written back |
| c_out | output | 1 | Updated carry flag |
| z_out | output | 1 | Updated zero flag |
| result | output | 8 | Byte to write back |

## Verification
Within a single operation, two things happen in the same cycle. A flag value is read and either steers or supplies the byte write, while the other flag, and every bit that is not selected, must stay untouched. The conditional forms and the Z stores consume Z at the same moment that C must pass through. The test form rewrites Z while C must hold. To reach all of these, the bench drives every opcode, including the undefined ones, with every bit index and every C/Z combination, over fixed and random operand bytes. It inserts idle cycles with garbage inputs between them. A behavioural model judges each cycle on all five outputs.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;
    localparam int unsigned OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD    = 5'd0,
        OP_ILOAD   = 5'd1,
        OP_AND     = 5'd2,
        OP_IAND    = 5'd3,
        OP_OR      = 5'd4,
        OP_IOR     = 5'd5,
        OP_XOR     = 5'd6,
        OP_IXOR    = 5'd7,
        OP_CSTORE  = 5'd8,
        OP_ICSTORE = 5'd9,
        OP_ZSTORE  = 5'd10,
        OP_IZSTORE = 5'd11,
        OP_SET     = 5'd12,
        OP_CLR     = 5'd13,
        OP_FLIP    = 5'd14,
        OP_TEST    = 5'd15,
        OP_SETEQ   = 5'd16,
        OP_SETNE   = 5'd17,
        OP_CLREQ   = 5'd18,
        OP_CLRNE   = 5'd19
    } bop_e;
endpackage

// File: rtl/bitproc_pick.sv
module bitproc_pick #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W-1:0] mask_o,
    output logic              sel_bit_o
);
    // one-hot decode of the bit index
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign mask_o[gi] = (sel_i == SEL_W'(gi));
    end

    assign sel_bit_o = |(operand_i & mask_o);
endmodule

// File: rtl/bitproc_flag.sv
module bitproc_flag
    import bitproc_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            sel_bit_i,
    input  logic            c_i,
    input  logic            z_i,
    output logic            c_o,
    output logic            z_o
);
    always_comb begin
        c_o = c_i;
        z_o = z_i;
        case (op_i)
            OP_LOAD:  c_o = sel_bit_i;
            OP_ILOAD: c_o = ~sel_bit_i;
            OP_AND:   c_o = c_i & sel_bit_i;
            OP_IAND:  c_o = c_i & ~sel_bit_i;
            OP_OR:    c_o = c_i | sel_bit_i;
            OP_IOR:   c_o = c_i | ~sel_bit_i;
            OP_XOR:   c_o = c_i ^ sel_bit_i;
            OP_IXOR:  c_o = c_i ^ ~sel_bit_i;
            OP_TEST:  z_o = ~sel_bit_i;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bitproc_write.sv
module bitproc_write
    import bitproc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              sel_bit_i,
    input  logic              c_i,
    input  logic              z_i,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_o
);
    logic new_bit;
    logic hit;

    always_comb begin
        new_bit = sel_bit_i;
        hit     = 1'b0;
        case (op_i)
            OP_CSTORE:  begin new_bit = c_i;        hit = 1'b1; end
            OP_ICSTORE: begin new_bit = ~c_i;       hit = 1'b1; end
            OP_ZSTORE:  begin new_bit = z_i;        hit = 1'b1; end
            OP_IZSTORE: begin new_bit = ~z_i;       hit = 1'b1; end
            OP_SET:     begin new_bit = 1'b1;       hit = 1'b1; end
            OP_CLR:     begin new_bit = 1'b0;       hit = 1'b1; end
            OP_FLIP:    begin new_bit = ~sel_bit_i; hit = 1'b1; end
            OP_SETEQ:   begin new_bit = 1'b1;       hit = z_i;  end
            OP_SETNE:   begin new_bit = 1'b1;       hit = ~z_i; end
            OP_CLREQ:   begin new_bit = 1'b0;       hit = z_i;  end
            OP_CLRNE:   begin new_bit = 1'b0;       hit = ~z_i; end
            default:    ;
        endcase
        data_o = hit ? ((operand_i & ~mask_i) | (mask_i & {DATA_W{new_bit}}))
                     : operand_i;
        wr_o   = hit;
    end
endmodule

// File: rtl/bitproc.sv
module bitproc
    import bitproc_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic              c_in,
    input  logic              z_in,
    output logic              out_valid,
    output logic              wr_en,
    output logic              c_out,
    output logic              z_out,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              vld;
        logic              wr;
        logic              cf;
        logic              zf;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    logic [DATA_W-1:0] mask;
    logic              sel_bit;
    logic              c_nx, z_nx, wr_nx;
    logic [DATA_W-1:0] data_nx;

    bitproc_pick #(.DATA_W(DATA_W)) u_pick (
        .operand_i (operand),
        .sel_i     (bit_sel),
        .mask_o    (mask),
        .sel_bit_o (sel_bit)
    );

    bitproc_flag u_flag (
        .op_i      (op),
        .sel_bit_i (sel_bit),
        .c_i       (c_in),
        .z_i       (z_in),
        .c_o       (c_nx),
        .z_o       (z_nx)
    );

    bitproc_write #(.DATA_W(DATA_W)) u_write (
        .op_i      (op),
        .operand_i (operand),
        .mask_i    (mask),
        .sel_bit_i (sel_bit),
        .c_i       (c_in),
        .z_i       (z_in),
        .data_o    (data_nx),
        .wr_o      (wr_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.wr  = 1'b0;
        if (in_valid) begin
            st_d.wr   = wr_nx;
            st_d.cf   = c_nx;
            st_d.zf   = z_nx;
            st_d.data = data_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign wr_en     = st_q.wr;
    assign c_out     = st_q.cf;
    assign z_out     = st_q.zf;
    assign result    = st_q.data;
endmodule

// File: rtl/bitproc_chk.sv
module bitproc_chk #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [4:0]        op,
    input logic [SEL_W-1:0]  bit_sel,
    input logic [DATA_W-1:0] operand,
    input logic              c_in,
    input logic              z_in,
    input logic              out_valid,
    input logic              wr_en,
    input logic              c_out,
    input logic              z_out,
    input logic [DATA_W-1:0] result
);
    assert_other_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((result ^ $past(operand)) & ~(DATA_W'(1) << $past(bit_sel))) == '0));

    assert_test_z_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 5'd15) |->
            (z_out == !$past(operand[bit_sel]) && c_out == $past(c_in)));

    assert_byte_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wr_en) |-> result == $past(operand));

    assert_flags_kept_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (c_out == $past(c_in) && z_out == $past(z_in)));

    assert_wr_opcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(op) >= 5'd8 && $past(op) <= 5'd19 && $past(op) != 5'd15));

    assert_single_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(result ^ $past(operand)) <= 1);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(c_out) && $stable(z_out) && !wr_en && !out_valid));

    assert_wr_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> out_valid);
endmodule

bind bitproc bitproc_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bitproc_bench.sv
`timescale 1ns/1ps
module bitproc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] operand = '0;
    logic       c_in = 1'b0;
    logic       z_in = 1'b0;
    logic       out_valid, wr_en, c_out, z_out;
    logic [7:0] result;

    int vectors = 0;
    int miscompares = 0;

    // expected registered state
    logic       e_vld = 1'b0, e_wr = 1'b0, e_c = 1'b0, e_z = 1'b0;
    logic [7:0] e_data = '0;
    string      e_tag = "R11";

    always #2 clk = ~clk;

    bitproc u_bitproc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .bit_sel(bit_sel),
        .operand(operand), .c_in(c_in), .z_in(z_in), .out_valid(out_valid),
        .wr_en(wr_en), .c_out(c_out), .z_out(z_out), .result(result)
    );

    function automatic string tag_of(int o);
        if (o <= 1)  return "R2";
        if (o <= 7)  return "R3";
        if (o <= 9)  return "R4";
        if (o <= 11) return "R5";
        if (o <= 14) return "R7";
        if (o == 15) return "R6";
        if (o <= 19) return "R8";
        return "R9";
    endfunction

    task automatic compare();
        bit bad = 0;
        vectors++;
        if (out_valid !== e_vld) begin
            $display("FAIL R11 out_valid act=%b exp=%b", out_valid, e_vld); bad = 1;
        end
        if (wr_en !== e_wr) begin
            $display("FAIL R10 (%s) wr_en act=%b exp=%b", e_tag, wr_en, e_wr); bad = 1;
        end
        if (c_out !== e_c) begin
            $display("FAIL %s c_out act=%b exp=%b", e_tag, c_out, e_c); bad = 1;
        end
        if (z_out !== e_z) begin
            $display("FAIL %s z_out act=%b exp=%b", e_tag, z_out, e_z); bad = 1;
        end
        if (result !== e_data) begin
            $display("FAIL %s/R1 result act=%h exp=%h", e_tag, result, e_data); bad = 1;
        end
        if (bad) miscompares++;
    endtask

    // behavioural reference for one valid operation
    task automatic model(input int o, input int s, input logic [7:0] v,
                         input logic c, input logic z);
        logic b = v[s];
        logic [7:0] nv = v;
        logic nc = c, nz = z, w = 0;
        case (o)
            0: nc = b;          1: nc = !b;
            2: nc = c && b;     3: nc = c && !b;
            4: nc = c || b;     5: nc = c || !b;
            6: nc = c != b;     7: nc = c == b;
            8: begin nv[s] = c;  w = 1; end
            9: begin nv[s] = !c; w = 1; end
            10: begin nv[s] = z;  w = 1; end
            11: begin nv[s] = !z; w = 1; end
            12: begin nv[s] = 1;  w = 1; end
            13: begin nv[s] = 0;  w = 1; end
            14: begin nv[s] = !b; w = 1; end
            15: nz = !b;
            16: if (z)  begin nv[s] = 1; w = 1; end
            17: if (!z) begin nv[s] = 1; w = 1; end
            18: if (z)  begin nv[s] = 0; w = 1; end
            19: if (!z) begin nv[s] = 0; w = 1; end
            default: ;
        endcase
        e_vld = 1; e_wr = w; e_c = nc; e_z = nz; e_data = nv; e_tag = tag_of(o);
    endtask

    task automatic drive_idle();
        in_valid = 0;
        op = 5'($urandom); bit_sel = 3'($urandom); operand = 8'($urandom);
        c_in = 1'($urandom); z_in = 1'($urandom);
        e_vld = 0; e_wr = 0; e_tag = "R11";
    endtask

    initial begin
        #(200000 * 4);
        $display("FAIL watchdog expired");
        miscompares++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int n = 0;
        // reset state: all outputs zero (R11)
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1;
        for (int p = 0; p < 6; p++) begin
            for (int o = 0; o < 32; o++) begin
                for (int s = 0; s < 8; s++) begin
                    for (int cz = 0; cz < 4; cz++) begin
                        logic [7:0] v;
                        case (p)
                            0: v = 8'h00;
                            1: v = 8'hFF;
                            2: v = 8'hA5;
                            3: v = 8'h3C;
                            default: v = 8'($urandom);
                        endcase
                        @(negedge clk);
                        compare();
                        n++;
                        if (n % 5 == 0) begin
                            drive_idle();
                            @(negedge clk);
                            compare();
                        end
                        in_valid = 1; op = 5'(o); bit_sel = 3'(s); operand = v;
                        c_in = cz[0]; z_in = cz[1];
                        model(o, s, v, cz[0], cz[1]);
                    end
                end
            end
        end
        @(negedge clk);
        compare();
        drive_idle();
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule